// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit arithmetic and logic stage of a small accumulator machine. Each cycle it takes an operation code, the accumulator value and a second operand. The second operand can come from a register, a memory byte or an immediate field. From these it forms the new result, a flag byte and a strobe that says whether the result belongs in the accumulator. All of that is combinational. The flag byte is also held in a register inside the block. That register loads the freshly computed flags on a clock edge when the flag write strobe is high. The stored carry is what the carry-routed rotates use, and it is also what increment, decrement and complement pass through unchanged.

The flag byte has a fixed layout: sign at bit 7, zero at bit 6, half carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 are always 0. Add, subtract, compare, increment and decrement share one adder. The adder also reports a carry out of the low nibble. Compare runs a subtraction only to set the flags, and it never asks for an accumulator write. Increment and decrement return the adjusted operand to whichever register or memory byte it came from.

The block has no state machine. Its only sequential element is the flag register: `flags_q` is reset to 0 and loads `flags_next` when `flag_we` is high.

Top module: `acc_alu_core`

## Requirements
- R1: The flag byte uses sign=bit 7, zero=bit 6, half carry=bit 4, parity=bit 2, carry=bit 0. Bits 5, 3 and 1 of `flags_next` and `flags_q` are always 0. While `rst_n` is low, `flags_q` is 0.
- R2: `flags_q` takes the value of `flags_next` on a rising clock edge only when `flag_we` is 1. Otherwise it holds its value.
- R3: Operation code 0 is add. `res_out` = acc + operand (mod 256). Carry is the carry out of bit 7 and half carry is the carry out of bit 3. `acc_we` is 1 for codes 0–4, 8, 9, 10, 11 and 12.
- R4: Operation code 1 is subtract. `res_out` = acc − operand (mod 256) and carry = 1 on a borrow (operand > acc). Half carry is the carry out of bit 3 of acc + ~operand + 1.
- R5: For add, subtract, AND, OR, XOR, increment and decrement, the flags are set from `res_out`. Sign is bit 7, zero is set when the result is 0, and parity is 1 when the result has an even number of ones.
- R6: Codes 2, 3 and 4 are AND, OR and XOR of acc with the operand. All three clear both carry and half carry.
- R7: Code 5 is compare. Its flags equal those that subtract would give for the same inputs. `res_out` equals acc and `acc_we` = 0.
- R8: Code 6 (increment) and code 7 (decrement) produce operand ± 1 on `res_out` with `acc_we` = 0. Sign, zero, parity and half carry are set from the internal addition of the operand with +1 or with all-ones. Carry keeps its stored value.
- R9: Code 8 is complement. `res_out` = ~acc and the operand is ignored. `flags_next` equals `flags_q`.
- R10: Code 9 rotates left circularly: bit 7 goes to both bit 0 and carry. Code 10 rotates right circularly: bit 0 goes to both bit 7 and carry.
- R11: Code 11 rotates left through carry: bit 7 goes to carry and the stored carry goes to bit 0. Code 12 rotates right through carry: bit 0 goes to carry and the stored carry goes to bit 7.
- R12: The four rotates change no flag other than carry.
- R13: Codes 13 to 15 are unused. They give `res_out` = acc, `acc_we` = 0 and `flags_next` = `flags_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation code (0–12 defined) |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand (register, memory or immediate byte) |
| flag_we | input | 1 | Load `flags_next` into the flag register at the next edge |
| res_out | output | 8 | Computed result |
| acc_we | output | 1 | Result is to be written to the accumulator |
| flags_next | output | 8 | Flag byte produced by this operation |
| flags_q | output | 8 | Stored flag byte |

## Verification
The flag register is the only stored state. A wrong value there shows up in two places. It appears on `flags_q` one edge after the faulty load. It also shows up in the same cycle on `flags_next` and `res_out` for any operation that passes flags through or reads the stored carry: complement, increment, decrement, the carry-routed rotates and the unused codes. The stimulus therefore loads a known flag byte before each operation. It then checks the combinational outputs before the next edge, so a corrupted carry or a load that should not have happened is visible within one cycle. Separate tests confirm that the register holds while `flag_we` is low and that reset clears it.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_CMP   = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_CPL   = 4'd8,
        OP_ROTL  = 4'd9,
        OP_ROTR  = 4'd10,
        OP_ROTLC = 4'd11,
        OP_ROTRC = 4'd12
    } alu_op_e;

    localparam int FLAG_W   = 8;
    localparam int FB_SIGN  = 7;
    localparam int FB_ZERO  = 6;
    localparam int FB_HALF  = 4;
    localparam int FB_PAR   = 2;
    localparam int FB_CARRY = 0;

    localparam logic [FLAG_W-1:0] FLAG_MASK =
        (8'd1 << FB_SIGN) | (8'd1 << FB_ZERO) | (8'd1 << FB_HALF) |
        (8'd1 << FB_PAR)  | (8'd1 << FB_CARRY);

    function automatic logic [FLAG_W-1:0] pack_flags(
        input logic s, input logic z, input logic h, input logic p, input logic c);
        logic [FLAG_W-1:0] f;
        f           = '0;
        f[FB_SIGN]  = s;
        f[FB_ZERO]  = z;
        f[FB_HALF]  = h;
        f[FB_PAR]   = p;
        f[FB_CARRY] = c;
        return f;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          hcarry
);
    localparam int HW = DW / 2;

    logic [HW:0] lo_sum;
    logic [DW:0] full_sum;

    // Low-nibble add, used only for the half carry.
    assign lo_sum   = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
    assign full_sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};

    assign sum    = full_sum[DW-1:0];
    assign cout   = full_sum[DW];
    assign hcarry = lo_sum[HW];
endmodule

// File: rtl/alu_rotate.sv
module alu_rotate #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic          cin,
    input  logic [1:0]    mode,   // 0 left circ, 1 right circ, 2 left via carry, 3 right via carry
    output logic [DW-1:0] y,
    output logic          cout
);
    always_comb begin
        unique case (mode)
            2'd0: begin y = {a[DW-2:0], a[DW-1]}; cout = a[DW-1]; end
            2'd1: begin y = {a[0], a[DW-1:1]};    cout = a[0];    end
            2'd2: begin y = {a[DW-2:0], cin};     cout = a[DW-1]; end
            default: begin y = {cin, a[DW-1:1]};  cout = a[0];    end
        endcase
    end
endmodule

// File: rtl/alu_flagcalc.sv
module alu_flagcalc #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] value,
    output logic          sign,
    output logic          zero,
    output logic          par_even
);
    assign sign     = value[DW-1];
    assign zero     = (value == '0);
    assign par_even = ~^value;
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic [DW-1:0]     acc_in,
    input  logic [DW-1:0]     opnd_in,
    input  logic              flag_we,
    output logic [DW-1:0]     res_out,
    output logic              acc_we,
    output logic [FLAG_W-1:0] flags_next,
    output logic [FLAG_W-1:0] flags_q
);
    localparam logic [3:0] ROT_BASE = 4'(OP_ROTL);

    alu_op_e     op;
    logic [DW-1:0] add_a, add_b, add_sum, logic_res, flag_src, rot_y;
    logic        add_cin, add_cout, add_half, rot_c;
    logic        f_sign, f_zero, f_par;
    logic [3:0]  rot_off;
    logic        is_logic;

    assign op      = alu_op_e'(op_sel);
    assign rot_off = op_sel - ROT_BASE;

    // Adder operand selection
    always_comb begin
        add_a   = acc_in;
        add_b   = opnd_in;
        add_cin = 1'b0;
        case (op)
            OP_SUB, OP_CMP: begin add_b = ~opnd_in; add_cin = 1'b1; end
            OP_INC:         begin add_a = opnd_in; add_b = '0; add_cin = 1'b1; end
            OP_DEC:         begin add_a = opnd_in; add_b = '1; add_cin = 1'b0; end
            default: ;
        endcase
    end

    always_comb begin
        is_logic  = 1'b1;
        logic_res = acc_in & opnd_in;
        case (op)
            OP_OR:   logic_res = acc_in | opnd_in;
            OP_XOR:  logic_res = acc_in ^ opnd_in;
            OP_AND:  logic_res = acc_in & opnd_in;
            default: is_logic = 1'b0;
        endcase
    end

    assign flag_src = is_logic ? logic_res : add_sum;

    alu_addsub #(.DW(DW)) u_add (
        .a(add_a), .b(add_b), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .hcarry(add_half)
    );

    alu_rotate #(.DW(DW)) u_rot (
        .a(acc_in), .cin(flags_q[FB_CARRY]), .mode(rot_off[1:0]),
        .y(rot_y), .cout(rot_c)
    );

    alu_flagcalc #(.DW(DW)) u_flg (
        .value(flag_src), .sign(f_sign), .zero(f_zero), .par_even(f_par)
    );

    // Result, write strobe and flag byte per operation
    always_comb begin
        res_out    = acc_in;
        acc_we     = 1'b0;
        flags_next = flags_q & FLAG_MASK;
        case (op)
            OP_ADD: begin
                res_out    = add_sum;
                acc_we     = 1'b1;
                flags_next = pack_flags(f_sign, f_zero, add_half, f_par, add_cout);
            end
            OP_SUB: begin
                res_out    = add_sum;
                acc_we     = 1'b1;
                flags_next = pack_flags(f_sign, f_zero, add_half, f_par, ~add_cout);
            end
            OP_CMP: begin
                flags_next = pack_flags(f_sign, f_zero, add_half, f_par, ~add_cout);
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_out    = logic_res;
                acc_we     = 1'b1;
                flags_next = pack_flags(f_sign, f_zero, 1'b0, f_par, 1'b0);
            end
            OP_INC, OP_DEC: begin
                res_out    = add_sum;
                flags_next = pack_flags(f_sign, f_zero, add_half, f_par, flags_q[FB_CARRY]);
            end
            OP_CPL: begin
                res_out = ~acc_in;
                acc_we  = 1'b1;
            end
            OP_ROTL, OP_ROTR, OP_ROTLC, OP_ROTRC: begin
                res_out              = rot_y;
                acc_we               = 1'b1;
                flags_next[FB_CARRY] = rot_c;
            end
            default: ;
        endcase
    end

    // Flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else if (flag_we)
            flags_q <= flags_next;
    end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_sel,
    input logic [DW-1:0]     acc_in,
    input logic              flag_we,
    input logic [DW-1:0]     res_out,
    input logic              acc_we,
    input logic [FLAG_W-1:0] flags_next,
    input logic [FLAG_W-1:0] flags_q
);
    logic is_rot, is_lgc, sets_szp;
    assign is_rot   = (op_sel >= 4'(OP_ROTL)) && (op_sel <= 4'(OP_ROTRC));
    assign is_lgc   = (op_sel == 4'(OP_AND)) || (op_sel == 4'(OP_OR)) || (op_sel == 4'(OP_XOR));
    assign sets_szp = (op_sel <= 4'(OP_DEC)) && (op_sel != 4'(OP_CMP));

    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[5] == 1'b0) && (flags_q[3] == 1'b0) && (flags_q[1] == 1'b0) &&
        (flags_next[5] == 1'b0) && (flags_next[3] == 1'b0) && (flags_next[1] == 1'b0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags_q));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags_q == $past(flags_next)));

    assert_szp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sets_szp |-> (flags_next[FB_ZERO] == (res_out == '0)) &&
                     (flags_next[FB_PAR] == ~^res_out) &&
                     (flags_next[FB_SIGN] == res_out[DW-1]));

    assert_logic_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_lgc |-> (flags_next[FB_CARRY] == 1'b0) && (flags_next[FB_HALF] == 1'b0));

    assert_cmp_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'(OP_CMP)) |-> (!acc_we && res_out == acc_in));

    assert_incdec_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_sel == 4'(OP_INC)) || (op_sel == 4'(OP_DEC))) |->
            (!acc_we && flags_next[FB_CARRY] == flags_q[FB_CARRY]));

    assert_cpl_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'(OP_CPL)) |-> (flags_next == flags_q && res_out == ~acc_in));

    assert_rot_only_carry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        is_rot |-> (flags_next[7:1] == flags_q[7:1]));

    assert_unused_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'(OP_ROTRC)) |-> (!acc_we && res_out == acc_in && flags_next == flags_q));
endmodule

bind acc_alu_core acc_alu_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in), .flag_we(flag_we),
    .res_out(res_out), .acc_we(acc_we), .flags_next(flags_next), .flags_q(flags_q)
);

// File: tb/sim_acc_alu_core.sv
module sim_acc_alu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] acc_in = 8'd0, opnd_in = 8'd0;
    logic       flag_we = 1'b0;
    logic [7:0] res_out, flags_next, flags_q;
    logic       acc_we;

    int tests_run = 0;
    int tests_failed = 0;

    always #5 clk = ~clk;

    acc_alu_core u0 (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in),
        .flag_we(flag_we), .res_out(res_out), .acc_we(acc_we),
        .flags_next(flags_next), .flags_q(flags_q)
    );

    // op | acc | opnd | preload(0:flags 44h, 1:flags 55h) | res | flags | acc_we
    localparam int NV = 23;
    localparam logic [43:0] VEC [NV] = '{
        44'h03A26060141,  // R3 add, half carry
        44'h0B56C021151,  // R3 add, carry out
        44'h0B34D000551,  // R3 R5 add to zero
        44'h1B5CC0E9811,  // R4 borrow
        44'h14505040101,  // R4 no borrow
        44'h2F03C130041,  // R6 and
        44'h38102183801,  // R6 or
        44'h45A5A100441,  // R6 xor to zero
        44'h52030020950,  // R7 compare less
        44'h54242142540,  // R7 compare equal
        44'h611FF000540,  // R8 inc wrap, carry kept 0
        44'h6007F180910,  // R8 inc, carry kept 1
        44'h755000FF840,  // R8 dec wrap
        44'h70001000540,  // R8 dec to zero
        44'h85CFF1A3551,  // R9 complement
        44'h9850000B451,  // R10 rotl
        44'hA85000C2451,  // R10 rotr
        44'hB850000A451,  // R11 rotl via carry
        44'hB050010B541,  // R11 rotl via carry, carry in 1
        44'hC8500042451,  // R11 rotr via carry
        44'hC84001C2541,  // R11 rotr via carry, carry in 1
        44'hD7712177550,  // R13 unused code
        44'hF0000000440   // R13 unused code
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2, 4'd3, 4'd4: return "R6";
            4'd5: return "R7";
            4'd6, 4'd7: return "R8";
            4'd8: return "R9";
            4'd9, 4'd10: return "R10";
            4'd11, 4'd12: return "R11";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // Load a known flag byte: p=0 -> 44h (AND 0,0), p=1 -> 55h (add FFh+01h)
    task automatic preload(input logic p);
        @(negedge clk);
        op_sel  = p ? 4'd0 : 4'd2;
        acc_in  = p ? 8'hFF : 8'h00;
        opnd_in = p ? 8'h01 : 8'h00;
        flag_we = 1'b1;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "flags_q in reset", flags_q, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "flags_q after reset", flags_q, 8'h00);

        // Table walk: flag bytes expected here carry 0 in bits 5,3,1 (R1); S/Z/P per R5
        for (int i = 0; i < NV; i++) begin
            preload(VEC[i][23:20] != 4'h0);
            op_sel  = VEC[i][43:40];
            acc_in  = VEC[i][39:32];
            opnd_in = VEC[i][31:24];
            #1;
            check(req_of(op_sel), "res_out", res_out, VEC[i][19:12]);
            check(req_of(op_sel), "flags_next", flags_next, VEC[i][11:4]);
            check(req_of(op_sel), "acc_we", {7'd0, acc_we}, {7'd0, VEC[i][0]});
        end

        // R2: no load without flag_we
        preload(1'b0);
        check("R2", "preload 44h", flags_q, 8'h44);
        op_sel = 4'd0; acc_in = 8'hFF; opnd_in = 8'h01; flag_we = 1'b0;
        @(posedge clk);
        #1;
        check("R2", "hold", flags_q, 8'h44);
        @(negedge clk);
        flag_we = 1'b1;
        @(posedge clk);
        #1;
        check("R2", "load", flags_q, 8'h55);
        @(negedge clk);
        flag_we = 1'b0;

        // R9: operand has no effect on complement
        op_sel = 4'd8; acc_in = 8'h0F; opnd_in = 8'h00;
        #1;
        check("R9", "cpl opnd 00", res_out, 8'hF0);
        opnd_in = 8'hA5;
        #1;
        check("R9", "cpl opnd A5", res_out, 8'hF0);
        check("R9", "cpl flags", flags_next, 8'h55);

        // R1: asynchronous reset clears the register mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "flags_q async reset", flags_q, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule